// File: doc/BRIEF.md
# Pointer Metadata Masking Unit

This unit sits on the address-generation path. It takes a 64-bit pointer and returns a linear address together with a canonical-fault flag. Depending on the access, it either applies the plain canonical-form test for the active paging depth or runs a privilege-specific test. In the second case it removes the software metadata held in the upper pointer bits, overwriting those bits with the checked top value.

Bit 63 of the pointer selects the privilege: 0 marks a user pointer and 1 marks a supervisor pointer. Each privilege has its own enable. Masking is allowed only when all three of these hold: the access is in 64-bit mode, it is a data access, and it is not the write of a control-register or MSR address. Every access is first sorted into one of seven check kinds: `K_PLAIN48`, `K_PLAIN57`, `K_SUP48`, `K_SUP57`, `K_USR48`, `K_USR57_L4` and `K_USR57_L5`. The kind chooses both the fault test and the bit rewrite.

The unit holds no sequential state beyond its output register. Each strobe takes the path "select kind → check and rewrite → register". The result appears one clock after the strobe. When no strobe is present, the outputs register to zero.

Top module: `ptr_meta_mask`

## Requirements
- R1: `out_vld` equals the previous cycle's `in_vld`. After reset, and in any cycle following a cycle without a strobe, `out_vld`, `out_fault` and `out_addr` are all 0.
- R2: Outside 64-bit mode, the pointer gets the plain check. Under 4-level paging (`paging5`=0), bits 63..47 must be all equal. Under 5-level paging (`paging5`=1), bits 63..56 must be all equal. A passing pointer is output unchanged.
- R3: In 64-bit mode, a non-data access (`data_acc`=0) gets the same plain check and pass-through as R2.
- R4: When `ctl_wr`=1, no masking is done, whatever the enables are. The plain check of R2 applies.
- R5: A masking-eligible pointer falls back to the plain check when the enable for its privilege is off. For supervisor (bit 63 = 1) the enable is `sup_en`. For user (bit 63 = 0) the enables are `usr48_en` and `usr57_en`.
- R6: Supervisor masking with 4-level paging faults unless bits 47 and 63 are both 1. When it passes, bits 62..48 are forced to 1.
- R7: Supervisor masking with 5-level paging faults unless bits 56 and 63 are both 1. When it passes, bits 62..57 are forced to 1.
- R8: User 48-bit masking, under either paging depth, faults unless bits 47 and 63 are both 0. When it passes, bits 62..48 are forced to 0.
- R9: User 57-bit masking with 4-level paging faults unless bits 56..47 and bit 63 are all 0. When it passes, bits 62..57 are forced to 0.
- R10: User 57-bit masking with 5-level paging faults unless bits 56 and 63 are both 0. When it passes, bits 62..57 are forced to 0.
- R11: When both user enables are set, the 57-bit user behaviour (R9/R10) applies.
- R12: Whenever `out_fault` is 1, `out_addr` is 0. In every non-faulting case, bit 63 and all bits below the usable width pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Access strobe |
| in_ptr | input | 64 | Pointer to check |
| long_mode | input | 1 | 64-bit mode active |
| data_acc | input | 1 | Access is a data access |
| paging5 | input | 1 | 1 = 5-level paging, 0 = 4-level |
| usr48_en | input | 1 | User 48-bit masking enable |
| usr57_en | input | 1 | User 57-bit masking enable |
| sup_en | input | 1 | Supervisor masking enable |
| ctl_wr | input | 1 | Pointer is written to a control register or MSR |
| out_vld | output | 1 | Result valid |
| out_addr | output | 64 | Linear address (0 on fault) |
| out_fault | output | 1 | Canonical fault |

## Verification
All 128 combinations of the seven control inputs are swept. For each combination, the unit is driven with four base pointers (user-canonical, supervisor-canonical, and two carrying metadata). Each base is applied unmodified and again with one of bits 47, 48, 56, 57, 62 and 63 flipped, and random pointers are added. The single-bit flips separate the check kinds: a flip at 47 or 56 moves a pointer across the boundary of one kind's test but not another's. A flip at 48 or 57 shows whether the rewrite range starts at the right width. A flip at 63 moves the pointer between the user and supervisor paths. An idle cycle and a control-register write with every enable set confirm the pass-through and zeroing behaviour.

// File: rtl/ptr_meta_mask_pkg.sv
package ptr_meta_mask_pkg;

    // Check kind chosen per access; drives both the fault test and rewrite.
    typedef enum logic [2:0] {
        K_PLAIN48  = 3'd0,
        K_PLAIN57  = 3'd1,
        K_SUP48    = 3'd2,
        K_SUP57    = 3'd3,
        K_USR48    = 3'd4,
        K_USR57_L4 = 3'd5,
        K_USR57_L5 = 3'd6
    } chk_kind_e;

endpackage

// File: rtl/ptrm_kind_sel.sv
module ptrm_kind_sel
    import ptr_meta_mask_pkg::*;
(
    input  logic      ptr_top,
    input  logic      long_mode,
    input  logic      data_acc,
    input  logic      paging5,
    input  logic      usr48_en,
    input  logic      usr57_en,
    input  logic      sup_en,
    input  logic      ctl_wr,
    output chk_kind_e kind
);

    logic      eligible;
    chk_kind_e plain_kind;

    always_comb begin
        eligible   = long_mode & data_acc & ~ctl_wr;
        plain_kind = paging5 ? K_PLAIN57 : K_PLAIN48;
        kind       = plain_kind;
        if (eligible) begin
            if (ptr_top) begin
                if (sup_en)
                    kind = paging5 ? K_SUP57 : K_SUP48;
            end else begin
                // 57-bit user width takes precedence over 48-bit
                if (usr57_en)
                    kind = paging5 ? K_USR57_L5 : K_USR57_L4;
                else if (usr48_en)
                    kind = K_USR48;
            end
        end
    end

endmodule

// File: rtl/ptrm_canon_chk.sv
module ptrm_canon_chk
    import ptr_meta_mask_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int NARROW_W = 48,
    parameter int WIDE_W   = 57
) (
    input  logic [PTR_W-1:0] ptr,
    input  chk_kind_e        kind,
    output logic             fault
);

    localparam int TOP = PTR_W - 1;
    localparam int NB  = NARROW_W - 1;
    localparam int WB  = WIDE_W - 1;

    logic [TOP-NB:0] hi_narrow;
    logic [TOP-WB:0] hi_wide;
    logic [WB-NB:0]  mid_band;

    always_comb begin
        hi_narrow = ptr[TOP:NB];
        hi_wide   = ptr[TOP:WB];
        mid_band  = ptr[WB:NB];
        fault     = 1'b0;
        unique case (kind)
            K_PLAIN48:  fault = !((&hi_narrow) || !(|hi_narrow));
            K_PLAIN57:  fault = !((&hi_wide) || !(|hi_wide));
            K_SUP48:    fault = !(ptr[NB] && ptr[TOP]);
            K_SUP57:    fault = !(ptr[WB] && ptr[TOP]);
            K_USR48:    fault = ptr[NB] || ptr[TOP];
            K_USR57_L4: fault = (|mid_band) || ptr[TOP];
            K_USR57_L5: fault = ptr[WB] || ptr[TOP];
            default:    fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptrm_rewrite.sv
module ptrm_rewrite
    import ptr_meta_mask_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int NARROW_W = 48,
    parameter int WIDE_W   = 57
) (
    input  logic [PTR_W-1:0] ptr,
    input  chk_kind_e        kind,
    output logic [PTR_W-1:0] addr
);

    localparam int TOP = PTR_W - 1;

    logic             fill;
    logic [PTR_W-1:0] narrow_addr;
    logic [PTR_W-1:0] wide_addr;

    assign fill = (kind == K_SUP48) || (kind == K_SUP57);

    // One bit-slice per position; the width parameter picks keep or fill.
    for (genvar i = 0; i < PTR_W; i++) begin : g_bit
        if (i < NARROW_W || i == TOP) begin : g_keep_n
            assign narrow_addr[i] = ptr[i];
        end else begin : g_fill_n
            assign narrow_addr[i] = fill;
        end
        if (i < WIDE_W || i == TOP) begin : g_keep_w
            assign wide_addr[i] = ptr[i];
        end else begin : g_fill_w
            assign wide_addr[i] = fill;
        end
    end

    always_comb begin
        addr = ptr;
        unique case (kind)
            K_PLAIN48, K_PLAIN57:            addr = ptr;
            K_SUP48, K_USR48:                addr = narrow_addr;
            K_SUP57, K_USR57_L4, K_USR57_L5: addr = wide_addr;
            default:                         addr = '0;
        endcase
    end

endmodule

// File: rtl/ptr_meta_mask.sv
module ptr_meta_mask
    import ptr_meta_mask_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int NARROW_W = 48,
    parameter int WIDE_W   = 57
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [PTR_W-1:0] in_ptr,
    input  logic             long_mode,
    input  logic             data_acc,
    input  logic             paging5,
    input  logic             usr48_en,
    input  logic             usr57_en,
    input  logic             sup_en,
    input  logic             ctl_wr,
    output logic             out_vld,
    output logic [PTR_W-1:0] out_addr,
    output logic             out_fault
);

    localparam int TOP = PTR_W - 1;

    chk_kind_e        kind;
    logic             chk_fault;
    logic [PTR_W-1:0] rw_addr;
    logic             nxt_vld;
    logic             nxt_fault;
    logic [PTR_W-1:0] nxt_addr;

    ptrm_kind_sel u_sel (
        .ptr_top   (in_ptr[TOP]),
        .long_mode (long_mode),
        .data_acc  (data_acc),
        .paging5   (paging5),
        .usr48_en  (usr48_en),
        .usr57_en  (usr57_en),
        .sup_en    (sup_en),
        .ctl_wr    (ctl_wr),
        .kind      (kind)
    );

    ptrm_canon_chk #(.PTR_W(PTR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
        .ptr   (in_ptr),
        .kind  (kind),
        .fault (chk_fault)
    );

    ptrm_rewrite #(.PTR_W(PTR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_rw (
        .ptr  (in_ptr),
        .kind (kind),
        .addr (rw_addr)
    );

    always_comb begin
        nxt_vld   = in_vld;
        nxt_fault = in_vld & chk_fault;
        nxt_addr  = (in_vld && !chk_fault) ? rw_addr : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            out_fault <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_vld   <= nxt_vld;
            out_fault <= nxt_fault;
            out_addr  <= nxt_addr;
        end
    end

endmodule

// File: rtl/ptr_meta_mask_chk.sv
module ptr_meta_mask_chk #(
    parameter int PTR_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [PTR_W-1:0] in_ptr,
    input logic             ctl_wr,
    input logic             out_vld,
    input logic [PTR_W-1:0] out_addr,
    input logic             out_fault
);

    // R1
    vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R1
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (out_addr == '0 && !out_fault));

    // R12
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> (out_addr == '0));

    // R4
    ctl_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ctl_wr) |=> (out_fault || out_addr == $past(in_ptr)));

    // R12
    top_bit_keep_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_fault || out_addr[PTR_W-1] == $past(in_ptr[PTR_W-1])));

endmodule

bind ptr_meta_mask ptr_meta_mask_chk #(.PTR_W(PTR_W)) u_ptr_meta_mask_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_ptr    (in_ptr),
    .ctl_wr    (ctl_wr),
    .out_vld   (out_vld),
    .out_addr  (out_addr),
    .out_fault (out_fault)
);

// File: tb/tb_ptr_meta_mask.sv
module tb_ptr_meta_mask;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [63:0] in_ptr = '0;
    logic        long_mode = 1'b0, data_acc = 1'b0, paging5 = 1'b0;
    logic        usr48_en = 1'b0, usr57_en = 1'b0, sup_en = 1'b0, ctl_wr = 1'b0;
    logic        out_vld;
    logic [63:0] out_addr;
    logic        out_fault;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ptr_meta_mask dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_ptr(in_ptr),
        .long_mode(long_mode), .data_acc(data_acc), .paging5(paging5),
        .usr48_en(usr48_en), .usr57_en(usr57_en), .sup_en(sup_en),
        .ctl_wr(ctl_wr), .out_vld(out_vld), .out_addr(out_addr),
        .out_fault(out_fault)
    );

    function automatic void check(input string tag, input string what,
                                  input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endfunction

    // Reference model written from the requirements.
    function automatic void model(input logic [6:0] cfg, input logic [63:0] p,
                                  output logic f, output logic [63:0] a,
                                  output string tag);
        logic lm, da, p5, u48, u57, se, cw, elig;
        int w;
        logic top;
        logic [63:0] hi, ones;
        {lm, da, p5, u48, u57, se, cw} = cfg;
        elig = lm && da && !cw;
        a = p;
        f = 1'b0;
        w = 0;
        top = 1'b0;
        if (elig && p[63] && se) begin
            w = p5 ? 57 : 48;
            top = 1'b1;
            f = !(p[w-1] && p[63]);
            tag = p5 ? "R7" : "R6";
        end else if (elig && !p[63] && (u57 || u48)) begin
            if (u57) begin
                w = 57;
                f = p[63] || p[56] || (!p5 && (p[56:47] != 10'd0));
                tag = u48 ? "R11" : (p5 ? "R10" : "R9");
            end else begin
                w = 48;
                f = p[63] || p[47];
                tag = "R8";
            end
        end else begin
            int cw_w;
            cw_w = p5 ? 57 : 48;
            hi   = p >> (cw_w - 1);
            ones = (64'd1 << (65 - cw_w)) - 64'd1;
            f    = !(hi == 64'd0 || hi == ones);
            if (cw)       tag = "R4";
            else if (!lm) tag = "R2";
            else if (!da) tag = "R3";
            else          tag = "R5";
        end
        if (w != 0)
            for (int i = w; i < 63; i++) a[i] = top;
        if (f) a = 64'd0;
    endfunction

    task automatic drive(input logic [6:0] cfg, input logic [63:0] p);
        logic f;
        logic [63:0] a;
        string tag;
        @(negedge clk);
        {long_mode, data_acc, paging5, usr48_en, usr57_en, sup_en, ctl_wr} = cfg;
        in_ptr = p;
        in_vld = 1'b1;
        @(negedge clk);
        model(cfg, p, f, a, tag);
        check("R1", "out_vld", {63'd0, out_vld}, 64'd1);
        check(tag, "out_fault", {63'd0, out_fault}, {63'd0, f});
        check(tag, "out_addr", out_addr, a);
        if (f) check("R12", "addr_on_fault", out_addr, 64'd0);
        else   check("R12", "bit63", {63'd0, out_addr[63]}, {63'd0, p[63]});
    endtask

    initial begin
        logic [63:0] bases [4];
        int flips [7];
        bases[0] = 64'h0000_7fff_ffff_f123;
        bases[1] = 64'hffff_8000_0000_0abc;
        bases[2] = 64'h5a3c_0123_4567_89ab;
        bases[3] = 64'hc5a1_8001_2345_6789;
        flips[0] = -1; flips[1] = 47; flips[2] = 48; flips[3] = 56;
        flips[4] = 57; flips[5] = 62; flips[6] = 63;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset out_vld", {63'd0, out_vld}, 64'd0);
        check("R1", "reset out_addr", out_addr, 64'd0);
        check("R1", "reset out_fault", {63'd0, out_fault}, 64'd0);
        rst = 1'b0;

        for (int c = 0; c < 128; c++) begin
            for (int b = 0; b < 4; b++) begin
                for (int k = 0; k < 7; k++) begin
                    logic [63:0] p;
                    p = bases[b];
                    if (flips[k] >= 0) p[flips[k]] = ~p[flips[k]];
                    drive(c[6:0], p);
                end
            end
            for (int r = 0; r < 4; r++)
                drive(c[6:0], {$urandom(), $urandom()});
        end

        // R1 idle cycle zeros the outputs
        @(negedge clk);
        in_vld = 1'b0;
        in_ptr = 64'hffff_ffff_ffff_ffff;
        @(negedge clk);
        check("R1", "idle out_vld", {63'd0, out_vld}, 64'd0);
        check("R1", "idle out_addr", out_addr, 64'd0);
        check("R1", "idle out_fault", {63'd0, out_fault}, 64'd0);

        // R4 control write with all enables on: metadata kept as-is
        drive(7'b1111111, 64'h0000_1234_5678_9abc);
        drive(7'b1111111, 64'h0100_1234_5678_9abc);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R1: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule